// File: doc/BRIEF.md
# Multi-Link Configuration Load Sequencer

This block coordinates the register setup of an external memory device during link bring-up when one or more link controllers share that device. Each link controller raises a load request when it is ready for the device to be configured. The block gathers these requests, and a per-link enable mask says which links take part. Once every enabled link is requesting, the block walks a fixed table of 16-bit address / 32-bit data pairs. It hands each pair in turn to a byte-level serial-bus write engine through a valid/ready command port. The engine answers each command with a one-cycle response that carries an error bit.

The table is built from parameters. Its final entry is always the device's initialization-continue register. If the write engine reports an error, the same entry is issued again, up to a parameterized number of retries. When the retries run out, the block parks in a sticky error state. When the final write succeeds, the block raises done to every enabled link in the same cycle. It holds done until all of those links have dropped their requests, and then lowers done, which closes a four-phase handshake. A status output shows the current phase and the index of the table entry being written.

Top module: `link_cfg_seq`

## Requirements
- R1: After reset, every done bit is 0, the status state is idle (code 0), cmd_valid_o is 0 and err_o is 0.
- R2: No command is issued while any enabled link has its request low. While at least one enabled request is high but not all of them are, the status state is gathering (code 1).
- R3: Links whose enable bit is 0 are ignored by the all-requested check and by the release check. Their done bits stay 0. A design with no enabled link never starts.
- R4: Table entries are issued in ascending index order, with one command outstanding at a time. Each entry's address and data are held stable while cmd_valid_o is high and cmd_ready_i is low. Entry i (i < N_ENTRIES-1) has address ADDR_BASE + i*ADDR_STEP and data DATA_SEED XOR (i * 0x01010101). The last entry has address INIT_CONT_ADDR (default 0x00ED) and data INIT_CONT_DATA.
- R5: Done rises in the cycle after the clock edge that accepts an error-free response to the last table entry, and never earlier.
- R6: The done bits of all links that were enabled at start rise together in one cycle, and equal the enable mask captured when writing began.
- R7: Done stays high while any captured-enabled request is still high. It drops in the cycle after those requests are all sampled low, and the state then returns to idle (code 0).
- R8: An error response reissues the same entry, up to MAX_RETRY retries (default 2) per entry. An error on the last allowed attempt moves the block to the error state (code 5). In that state err_o is high and stays high until reset, and done never rises.
- R9: A request that falls and rises again while done is still high starts no new writes. A new load begins only from idle, after done has dropped.
- R10: stat_state_o encodes idle=0, gathering=1, writing=2, done=3, awaiting release=4, error=5. stat_index_o gives the index of the current table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_req_i | input | N_LINKS | Load request from each link controller |
| link_en_i | input | N_LINKS | Per-link participation mask |
| link_done_o | output | N_LINKS | Configuration-complete indication to each link |
| cmd_valid_o | output | 1 | Write command valid |
| cmd_ready_i | input | 1 | Write engine accepts command |
| cmd_addr_o | output | 16 | Register address of the command |
| cmd_data_o | output | 32 | Register data of the command |
| rsp_valid_i | input | 1 | One-cycle completion from the write engine |
| rsp_err_i | input | 1 | Completion reports an error (not acknowledged) |
| err_o | output | 1 | Sticky failure flag |
| stat_state_o | output | 3 | Current phase code |
| stat_index_o | output | IDXW | Index of current table entry |

## Verification
Every result of this block is due one clock after the edge that samples its cause. The gathering and writing states appear one cycle after the requests are sampled. Done appears one cycle after the last good response is accepted, and it drops one cycle after the final request is seen low. The next command's valid and address appear one cycle after a good response, and the error state appears one cycle after the exhausting error. The bench drives all inputs on the falling edge. Its behavioural model advances on the rising edge from the same inputs, and every output is compared with the model at the following falling edge, so each check lands exactly in the cycle where the result is due.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GATHER  = 3'd1,
    ST_WRITE   = 3'd2,
    ST_DONE    = 3'd3,
    ST_RELEASE = 3'd4,
    ST_ERROR   = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic [15:0] addr;
    logic [31:0] data;
  } cfg_entry_t;

  // Table entry i; the final index is the initialization-continue write.
  function automatic cfg_entry_t table_entry(
    input int unsigned idx,
    input int unsigned count,
    input logic [15:0] base,
    input logic [15:0] step,
    input logic [31:0] seed,
    input logic [15:0] ic_addr,
    input logic [31:0] ic_data
  );
    cfg_entry_t e;
    if (idx == count - 1) begin
      e.addr = ic_addr;
      e.data = ic_data;
    end else begin
      e.addr = base + 16'(idx) * step;
      e.data = seed ^ (32'(idx) * 32'h0101_0101);
    end
    return e;
  endfunction

endpackage

// File: rtl/cfg_req_gather.sv
module cfg_req_gather #(
  parameter int N_LINKS = 3
) (
  input  logic [N_LINKS-1:0] req_i,
  input  logic [N_LINKS-1:0] en_i,
  output logic               all_req_o,
  output logic               any_req_o
);

  function automatic logic every_enabled_set(input logic [N_LINKS-1:0] r,
                                             input logic [N_LINKS-1:0] m);
    return (m != '0) && ((r & m) == m);
  endfunction

  assign all_req_o = every_enabled_set(req_i, en_i);
  assign any_req_o = |(req_i & en_i);

endmodule

// File: rtl/cfg_table_rom.sv
module cfg_table_rom #(
  parameter int          N_ENTRIES      = 4,
  parameter int          IDXW           = 2,
  parameter logic [15:0] ADDR_BASE      = 16'h0280,
  parameter logic [15:0] ADDR_STEP      = 16'h0004,
  parameter logic [31:0] DATA_SEED      = 32'hC0DE_0000,
  parameter logic [15:0] INIT_CONT_ADDR = 16'h00ED,
  parameter logic [31:0] INIT_CONT_DATA = 32'h0000_0001
) (
  input  logic [IDXW-1:0]           idx_i,
  output cfg_seq_pkg::cfg_entry_t   entry_o
);
  import cfg_seq_pkg::*;

  cfg_entry_t tbl [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    assign tbl[g] = table_entry(g, N_ENTRIES, ADDR_BASE, ADDR_STEP,
                                DATA_SEED, INIT_CONT_ADDR, INIT_CONT_DATA);
  end

  always_comb begin
    entry_o = '0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      if (idx_i == IDXW'(k)) entry_o = tbl[k];
    end
  end

endmodule

// File: rtl/cfg_write_issuer.sv
module cfg_write_issuer #(
  parameter int MAX_RETRY = 2,
  parameter int RETW      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic cmd_ready_i,
  input  logic rsp_valid_i,
  input  logic rsp_err_i,
  output logic cmd_valid_o,
  output logic write_ok_o,
  output logic write_fail_o
);

  logic            wait_rsp;
  logic [RETW-1:0] retry_q;
  logic            exhausted;
  logic            rsp_seen;

  function automatic logic [RETW-1:0] retry_bump(input logic [RETW-1:0] r);
    return r + RETW'(1);
  endfunction

  assign exhausted    = (retry_q == RETW'(MAX_RETRY));
  assign rsp_seen     = active_i && wait_rsp && rsp_valid_i;
  assign cmd_valid_o  = active_i && !wait_rsp;
  assign write_ok_o   = rsp_seen && !rsp_err_i;
  assign write_fail_o = rsp_seen && rsp_err_i && exhausted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_rsp <= 1'b0;
      retry_q  <= '0;
    end else if (!active_i) begin
      wait_rsp <= 1'b0;
      retry_q  <= '0;
    end else if (!wait_rsp) begin
      if (cmd_ready_i) wait_rsp <= 1'b1;
    end else if (rsp_valid_i) begin
      wait_rsp <= 1'b0;
      if (!rsp_err_i)      retry_q <= '0;
      else if (!exhausted) retry_q <= retry_bump(retry_q);
    end
  end

endmodule

// File: rtl/link_cfg_seq.sv
module link_cfg_seq #(
  parameter int          N_LINKS        = 3,
  parameter int          N_ENTRIES      = 4,
  parameter int          MAX_RETRY      = 2,
  parameter logic [15:0] ADDR_BASE      = 16'h0280,
  parameter logic [15:0] ADDR_STEP      = 16'h0004,
  parameter logic [31:0] DATA_SEED      = 32'hC0DE_0000,
  parameter logic [15:0] INIT_CONT_ADDR = 16'h00ED,
  parameter logic [31:0] INIT_CONT_DATA = 32'h0000_0001,
  localparam int         IDXW           = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINKS-1:0] link_req_i,
  input  logic [N_LINKS-1:0] link_en_i,
  output logic [N_LINKS-1:0] link_done_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic [15:0]        cmd_addr_o,
  output logic [31:0]        cmd_data_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_err_i,
  output logic               err_o,
  output logic [2:0]         stat_state_o,
  output logic [IDXW-1:0]    stat_index_o
);
  import cfg_seq_pkg::*;

  localparam int RETW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  seq_state_e         st_q, st_n;
  logic [IDXW-1:0]    idx_q, idx_n;
  logic [N_LINKS-1:0] en_snap, snap_n;
  logic               all_req, any_req;
  logic               write_ok, write_fail;
  logic               writing;
  logic               done_phase;
  logic               snap_busy;
  cfg_entry_t         cur_entry;

  function automatic logic is_last(input logic [IDXW-1:0] i);
    return i == IDXW'(N_ENTRIES - 1);
  endfunction

  function automatic logic [IDXW-1:0] idx_step(input logic [IDXW-1:0] i);
    return i + IDXW'(1);
  endfunction

  cfg_req_gather #(.N_LINKS(N_LINKS)) u_gather (
    .req_i     (link_req_i),
    .en_i      (link_en_i),
    .all_req_o (all_req),
    .any_req_o (any_req)
  );

  cfg_table_rom #(
    .N_ENTRIES      (N_ENTRIES),
    .IDXW           (IDXW),
    .ADDR_BASE      (ADDR_BASE),
    .ADDR_STEP      (ADDR_STEP),
    .DATA_SEED      (DATA_SEED),
    .INIT_CONT_ADDR (INIT_CONT_ADDR),
    .INIT_CONT_DATA (INIT_CONT_DATA)
  ) u_rom (
    .idx_i   (idx_q),
    .entry_o (cur_entry)
  );

  cfg_write_issuer #(.MAX_RETRY(MAX_RETRY), .RETW(RETW)) u_issuer (
    .clk          (clk),
    .rst_n        (rst_n),
    .active_i     (writing),
    .cmd_ready_i  (cmd_ready_i),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_err_i    (rsp_err_i),
    .cmd_valid_o  (cmd_valid_o),
    .write_ok_o   (write_ok),
    .write_fail_o (write_fail)
  );

  assign writing    = (st_q == ST_WRITE);
  assign done_phase = (st_q == ST_DONE) || (st_q == ST_RELEASE);
  assign snap_busy  = |(link_req_i & en_snap);

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    snap_n = en_snap;
    unique case (st_q)
      ST_IDLE, ST_GATHER: begin
        if (all_req) begin
          st_n   = ST_WRITE;
          idx_n  = '0;
          snap_n = link_en_i;
        end else if (any_req) begin
          st_n = ST_GATHER;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_WRITE: begin
        if (write_fail) begin
          st_n = ST_ERROR;
        end else if (write_ok) begin
          if (is_last(idx_q)) st_n = ST_DONE;
          else                idx_n = idx_step(idx_q);
        end
      end
      ST_DONE:    st_n = ST_RELEASE;
      ST_RELEASE: if (!snap_busy) st_n = ST_IDLE;
      ST_ERROR:   st_n = ST_ERROR;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      en_snap <= '0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      en_snap <= snap_n;
    end
  end

  for (genvar l = 0; l < N_LINKS; l++) begin : g_done
    assign link_done_o[l] = done_phase && en_snap[l];
  end

  assign cmd_addr_o   = cur_entry.addr;
  assign cmd_data_o   = cur_entry.data;
  assign err_o        = (st_q == ST_ERROR);
  assign stat_state_o = st_q;
  assign stat_index_o = idx_q;

endmodule

// File: rtl/link_cfg_seq_chk.sv
module link_cfg_seq_chk #(
  parameter int N_LINKS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINKS-1:0] req,
  input logic [N_LINKS-1:0] done,
  input logic [N_LINKS-1:0] snap,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [15:0]        cmd_addr,
  input logic [31:0]        cmd_data,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic               err,
  input logic [2:0]         state
);

  // R2: no command outside the writing state
  p_no_cmd_outside_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd2) |-> !cmd_valid);

  // R4: a stalled command keeps its address and data
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  // R5: done rises only right after a good response
  p_done_after_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|done) |-> $past(rsp_valid && !rsp_err));

  // R6: done bits match the captured mask whenever any is high
  p_done_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> (done == snap));

  // R7: done held while a participating request is high
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|done) && (|(req & done))) |=> (|done));

  // R7: done drops once participating requests are low in release
  p_done_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 3'd4) && ((req & done) == '0)) |=> (done == '0));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8: no done while in error
  p_err_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done == '0));

endmodule

bind link_cfg_seq link_cfg_seq_chk #(.N_LINKS(N_LINKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (link_req_i),
  .done      (link_done_o),
  .snap      (en_snap),
  .cmd_valid (cmd_valid_o),
  .cmd_ready (cmd_ready_i),
  .cmd_addr  (cmd_addr_o),
  .cmd_data  (cmd_data_o),
  .rsp_valid (rsp_valid_i),
  .rsp_err   (rsp_err_i),
  .err       (err_o),
  .state     (stat_state_o)
);

// File: tb/sim_link_cfg_seq.sv
`timescale 1ns/1ps
module sim_link_cfg_seq;

  localparam int NL = 3;
  localparam int NE = 4;
  localparam int MR = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req = '0;
  logic [NL-1:0] en = '0;
  logic [NL-1:0] done;
  logic          cmd_valid, cmd_ready = 1'b1;
  logic [15:0]   cmd_addr;
  logic [31:0]   cmd_data;
  logic          rsp_valid = 1'b0, rsp_err = 1'b0;
  logic          err;
  logic [2:0]    stat_state;
  logic [1:0]    stat_index;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 0;
  bit cmp_on = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_cfg_seq u0 (
    .clk(clk), .rst_n(rst_n), .link_req_i(req), .link_en_i(en),
    .link_done_o(done), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .rsp_valid_i(rsp_valid),
    .rsp_err_i(rsp_err), .err_o(err), .stat_state_o(stat_state),
    .stat_index_o(stat_index)
  );

  // Expected table, restated from R4
  function automatic logic [15:0] exp_addr(int i);
    if (i == NE - 1) return 16'h00ED;
    return 16'h0280 + 16'(4 * i);
  endfunction
  function automatic logic [31:0] exp_data(int i);
    logic [7:0] b;
    if (i == NE - 1) return 32'h1;
    b = 8'(i);
    return 32'hC0DE_0000 ^ {b, b, b, b};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int          m_state, m_idx, m_retry;
  bit          m_wait;
  logic [NL-1:0] m_snap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_idx = 0; m_retry = 0; m_wait = 0; m_snap = '0;
    end else begin
      bit all_r, any_r;
      all_r = (en != 0) && ((req & en) == en);
      any_r = (req & en) != 0;
      if (m_state == 0 || m_state == 1) begin
        if (all_r) begin
          m_state = 2; m_idx = 0; m_snap = en; m_wait = 0; m_retry = 0;
        end else m_state = any_r ? 1 : 0;
      end else if (m_state == 2) begin
        if (!m_wait) begin
          if (cmd_ready) m_wait = 1;
        end else if (rsp_valid) begin
          m_wait = 0;
          if (!rsp_err) begin
            m_retry = 0;
            if (m_idx == NE - 1) m_state = 3; else m_idx++;
          end else if (m_retry == MR) begin
            m_state = 5;
          end else m_retry++;
        end
      end else if (m_state == 3) begin
        m_state = 4;
      end else if (m_state == 4) begin
        if ((req & m_snap) == 0) m_state = 0;
      end
    end
  end

  // Write-engine responder bookkeeping
  bit          hs_seen = 0;
  logic [15:0] hs_addr;
  int          pend = 0;
  bit          cur_err = 0;
  bit          err_plan[$];
  logic [15:0] wlog[$];

  always @(posedge clk) begin
    hs_seen <= cmd_valid && cmd_ready;
    hs_addr <= cmd_addr;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      logic [NL-1:0] e_done;
      bit e_valid;
      e_done  = (m_state == 3 || m_state == 4) ? m_snap : '0;
      e_valid = (m_state == 2) && !m_wait;
      check(done == e_done, "R6 done vector", done, e_done);
      check(cmd_valid == e_valid, "R4 cmd_valid", cmd_valid, e_valid);
      if (e_valid) begin
        check(cmd_addr == exp_addr(m_idx), "R4 cmd_addr", cmd_addr, exp_addr(m_idx));
        check(cmd_data == exp_data(m_idx), "R4 cmd_data", cmd_data, exp_data(m_idx));
      end
      check(stat_state == 3'(m_state), "R10 state", stat_state, m_state);
      check(stat_index == 2'(m_idx), "R10 index", stat_index, m_idx);
      check(err == (m_state == 5), "R8 err flag", err, m_state == 5);
    end
    // responder
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin rsp_valid = 1'b1; rsp_err = cur_err; end
    end
    if (hs_seen) begin
      pend = 2;
      cur_err = (err_plan.size() > 0) ? err_plan.pop_front() : 1'b0;
      wlog.push_back(hs_addr);
    end
    cmd_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_run();
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done != 0) begin seen = 1; break; end
    end
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    check(done == 0, "R1 done after reset", done, 0);
    check(stat_state == 0, "R1 state after reset", stat_state, 0);
    check(cmd_valid == 0, "R1 cmd_valid after reset", cmd_valid, 0);
    check(err == 0, "R1 err after reset", err, 0);

    // Test A: three links, staggered requests
    en = 3'b111;
    req = 3'b001;
    repeat (2) @(negedge clk);
    req = 3'b011;
    repeat (4) @(negedge clk);
    check(stat_state == 1, "R2 gathering state", stat_state, 1);
    check(wlog.size() == 0, "R2 no writes while partial", wlog.size(), 0);
    req = 3'b111;
    @(negedge clk);
    check(stat_state == 2, "R10 writing state", stat_state, 2);
    wait_done(seen);
    check(seen, "R5 done reached", seen, 1);
    check(done == 3'b111, "R6 all done same cycle", done, 3'b111);
    check(wlog.size() == NE, "R5 all writes before done", wlog.size(), NE);
    for (int i = 0; i < NE; i++)
      if (i < wlog.size())
        check(wlog[i] == exp_addr(i), "R4 write order", wlog[i], exp_addr(i));
    check(wlog[wlog.size()-1] == 16'h00ED, "R4 final init-continue", wlog[wlog.size()-1], 16'h00ED);
    req = 3'b100;
    repeat (3) @(negedge clk);
    check(done == 3'b111, "R7 done held", done, 3'b111);
    req = 3'b000;
    @(negedge clk);
    check(done == 0, "R7 done dropped", done, 0);
    check(stat_state == 0, "R7 back to idle", stat_state, 0);

    // Test B: mask excludes link 1, early re-request held off
    wlog.delete();
    en = 3'b101;
    req = 3'b101;
    wait_done(seen);
    check(done == 3'b101, "R3 masked done", done, 3'b101);
    check(done[1] == 1'b0, "R3 disabled link done low", done[1], 0);
    req = 3'b100;
    @(negedge clk);
    req = 3'b101;
    repeat (6) @(negedge clk);
    check(wlog.size() == NE, "R9 no writes during hold-off", wlog.size(), NE);
    check(done == 3'b101, "R9 done still high", done, 3'b101);
    req = 3'b010;
    @(negedge clk);
    check(done == 0, "R3 disabled request ignored at release", done, 0);
    repeat (4) @(negedge clk);
    check(stat_state == 0, "R3 disabled request ignored at start", stat_state, 0);
    req = 3'b000;
    en = 3'b000;
    req = 3'b111;
    repeat (4) @(negedge clk);
    check(stat_state == 0, "R3 no enabled link never starts", stat_state, 0);
    req = 3'b000;
    @(negedge clk);

    // Test C: retries succeed, with ready stalls
    wlog.delete();
    stall_mode = 1;
    err_plan = '{0, 1, 1, 0, 0, 0};
    en = 3'b001;
    req = 3'b001;
    wait_done(seen);
    check(seen, "R8 retry then done", seen, 1);
    check(wlog.size() == NE + 2, "R8 retry count", wlog.size(), NE + 2);
    if (wlog.size() == NE + 2) begin
      check(wlog[1] == exp_addr(1) && wlog[2] == exp_addr(1) && wlog[3] == exp_addr(1),
            "R8 same entry reissued", wlog[2], exp_addr(1));
    end
    req = 3'b000;
    repeat (2) @(negedge clk);
    stall_mode = 0;

    // Test D: retries exhausted
    wlog.delete();
    err_plan = '{1, 1, 1};
    req = 3'b001;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (err) break;
    end
    check(err == 1, "R8 error raised", err, 1);
    check(stat_state == 5, "R8 error state code", stat_state, 5);
    check(wlog.size() == MR + 1, "R8 attempts before error", wlog.size(), MR + 1);
    req = 3'b000;
    repeat (10) @(negedge clk);
    check(err == 1, "R8 error sticky", err, 1);
    check(done == 0, "R8 no done in error", done, 0);
    finish_run();
  end

endmodule